// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

A synchronous up-counter built from identical 4-bit slices. Each slice has a synchronous active-low clear, a synchronous active-low parallel preset, two count enables and a terminal-carry output. The first enable is a "parallel" enable that affects only the slice's own counting. The second is a "trickle" enable that also gates the terminal carry. Because the two enables are separate, slices can be chained either as a plain ripple of carries or with lookahead carry wiring.

The top level chains `STAGES` slices into one wide counter. All slices share the clock, the clear and the preset. The preset data bus is split into one 4-bit field per slice, with slice 0 in the least significant bits. The counter is used as a wide modulo-2^(4·STAGES) counter. Its top-level enables and its carry output keep the same meaning as those of one slice, so several wide counters can themselves be chained.

Top module: `cnt_chain`

## Requirements
- R1: When `clr_n` is low at a rising edge, every bit of `q` becomes 0 after that edge, whatever `load_n`, `en_par`, `en_trk` and `din` are.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` after that edge, whatever `en_par` and `en_trk` are.
- R3: When `clr_n`, `load_n`, `en_par` and `en_trk` are all high at a rising edge, `q` increases by one modulo 2^(4·STAGES).
- R4: When `clr_n` and `load_n` are high and either `en_par` or `en_trk` is low at a rising edge, `q` keeps its value. This includes the case where slice 0 is at all ones.
- R5: Counting from the all-ones value returns `q` to zero.
- R6: `tc` is a combinational output. It is 1 exactly when `q` is all ones and `en_trk` is 1, and it does not depend on `en_par`, `load_n` or `clr_n`.
- R7: A carry crosses every 4-bit slice boundary: a slice advances only on the count edge where all lower slices are at all ones.
- R8: `q` changes only at rising clock edges. A change of `clr_n`, `load_n`, the enables or `din` between edges leaves `q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest precedence |
| load_n | input | 1 | Synchronous parallel preset, active low |
| en_par | input | 1 | Count enable that does not gate the carry output |
| en_trk | input | 1 | Count enable that also gates the carry output |
| din | input | 4·STAGES | Preset value; slice k uses bits 4k+3..4k |
| q | output | 4·STAGES | Current count |
| tc | output | 1 | Terminal carry: count all ones and `en_trk` high |

## Verification
The assertions check on every cycle, in each slice and on the whole chain, that a clear, a preset, a count or a hold gives the next value that the precedence order requires. They also check that the carry output matches the all-ones condition gated by the trickle enable. Some behaviour can only be shown by the bench's scenarios: a held chain parked at a slice boundary, wraparound of the full width, and a carry crossing into the second and third slices. The bench also shows that mid-cycle input changes leave the count untouched, and that presets, clears and enables interleave correctly over a long mixed sequence checked against a wide reference count.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   localparam int SLICE_W = 4;

   typedef enum logic [1:0] {
      M_CLEAR = 2'd0,
      M_LOAD  = 2'd1,
      M_COUNT = 2'd2,
      M_HOLD  = 2'd3
   } mode_t;

   // Fixed precedence: clear, then preset, then count, then hold.
   function automatic mode_t pick_mode(input logic clr_n, input logic load_n,
                                       input logic go);
      if (!clr_n)       return M_CLEAR;
      else if (!load_n) return M_LOAD;
      else if (go)      return M_COUNT;
      else              return M_HOLD;
   endfunction

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
   import cnt_pkg::*;
#(
   parameter int W = SLICE_W
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         load_n,
   input  logic         en_par,
   input  logic         en_trk,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         tc
);

   localparam logic [W-1:0] ONE = W'(1);

   if (W < 1) begin : g_bad_w
      $error("cnt_stage: W must be at least 1");
   end

   mode_t mode;
   assign mode = pick_mode(clr_n, load_n, en_par & en_trk);

   always_ff @(posedge clk) begin
      case (mode)
         M_CLEAR: q <= '0;
         M_LOAD:  q <= din;
         M_COUNT: q <= q + ONE;
         default: q <= q;
      endcase
   end

   assign tc = (&q) & en_trk;

   // Check window opens once a clear has defined the state.
   logic chk_armed = 1'b0;
   always_ff @(posedge clk) if (!clr_n) chk_armed <= 1'b1;

   // R1
   st_clear_chk: assert property (@(posedge clk) disable iff (!chk_armed)
      !clr_n |=> (q == '0));
   // R2
   st_load_chk: assert property (@(posedge clk) disable iff (!chk_armed)
      (clr_n && !load_n) |=> (q == $past(din)));
   // R3
   st_count_chk: assert property (@(posedge clk) disable iff (!chk_armed)
      (clr_n && load_n && en_par && en_trk) |=> (q == $past(q) + ONE));
   // R4
   st_hold_chk: assert property (@(posedge clk) disable iff (!chk_armed)
      (clr_n && load_n && !(en_par && en_trk)) |=> $stable(q));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
   import cnt_pkg::*;
#(
   parameter int STAGES    = 3,
   parameter int W         = SLICE_W,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic                  clk,
   input  logic                  clr_n,
   input  logic                  load_n,
   input  logic                  en_par,
   input  logic                  en_trk,
   input  logic [STAGES*W-1:0]   din,
   output logic [STAGES*W-1:0]   q,
   output logic                  tc
);

   localparam int TOTAL_W = STAGES * W;
   localparam logic [TOTAL_W-1:0] ONE = TOTAL_W'(1);

   if (STAGES < 1) begin : g_bad_stages
      $error("cnt_chain: STAGES must be at least 1");
   end
   if (W < 1) begin : g_bad_w
      $error("cnt_chain: W must be at least 1");
   end

   logic [STAGES-1:0] tc_s;
   logic [STAGES-1:0] ep_s;
   logic [STAGES-1:0] et_s;

   for (genvar g = 0; g < STAGES; g++) begin : g_slice
      if (g == 0) begin : g_first
         assign ep_s[g] = en_par;
         assign et_s[g] = en_trk;
      end else begin : g_rest
         assign et_s[g] = tc_s[g-1];
         if (LOOKAHEAD) begin : g_look
            // Lookahead: slice 0's carry (qualified by the top enable)
            // reaches every higher slice directly.
            assign ep_s[g] = en_par & tc_s[0];
         end else begin : g_ripple
            assign ep_s[g] = en_par;
         end
      end

      cnt_stage #(.W(W)) u_stage (
         .clk    (clk),
         .clr_n  (clr_n),
         .load_n (load_n),
         .en_par (ep_s[g]),
         .en_trk (et_s[g]),
         .din    (din[g*W +: W]),
         .q      (q[g*W +: W]),
         .tc     (tc_s[g])
      );
   end

   assign tc = tc_s[STAGES-1];

   logic chk_armed = 1'b0;
   always_ff @(posedge clk) if (!clr_n) chk_armed <= 1'b1;

   // R3 R5 R7
   chain_count_chk: assert property (@(posedge clk) disable iff (!chk_armed)
      (clr_n && load_n && en_par && en_trk) |=> (q == $past(q) + ONE));
   // R4
   chain_hold_chk: assert property (@(posedge clk) disable iff (!chk_armed)
      (clr_n && load_n && !(en_par && en_trk)) |=> $stable(q));
   // R6
   chain_tc_chk: assert property (@(posedge clk) disable iff (!chk_armed)
      tc == ((&q) && en_trk));

endmodule

// File: tb/cnt_chain_bench.sv
`timescale 1ns/1ps
module cnt_chain_bench;

   localparam int STAGES = 3;
   localparam int TW     = STAGES * 4;
   localparam logic [TW-1:0] ALL1 = '1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          clr_n  = 1'b0;
   logic          load_n = 1'b1;
   logic          en_par = 1'b0;
   logic          en_trk = 1'b0;
   logic [TW-1:0] din    = '0;
   logic [TW-1:0] q;
   logic          tc;

   cnt_chain #(.STAGES(STAGES)) u_cnt_chain (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
      .en_trk(en_trk), .din(din), .q(q), .tc(tc)
   );

   int n_chk  = 0;
   int n_fail = 0;
   logic [TW-1:0] model = '0;
   logic [TW-1:0] exp_q[$];
   string         exp_tag[$];

   task automatic check(input bit ok, input string tag,
                        input logic [TW-1:0] act, input logic [TW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: set inputs after a falling edge, check the combinational and
   // unchanged-state view, then queue the value expected after the next edge.
   task automatic step(input logic c, input logic l, input logic p,
                       input logic t, input logic [TW-1:0] d, input string tag);
      logic exp_tc;
      @(negedge clk);
      clr_n = c; load_n = l; en_par = p; en_trk = t; din = d;
      #1;
      check(q === model, "R8 q steady between edges", q, model);
      exp_tc = (model == ALL1) && t;
      check(tc === exp_tc, "R6 tc", {{(TW-1){1'b0}}, tc}, {{(TW-1){1'b0}}, exp_tc});
      if (!c)        model = '0;
      else if (!l)   model = d;
      else if (p && t) model = model + 1'b1;
      exp_q.push_back(model);
      exp_tag.push_back(tag);
   endtask

   // Monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [TW-1:0] e;
            string s;
            e = exp_q.pop_front();
            s = exp_tag.pop_front();
            check(q === e, s, q, e);
         end
      end
   end

   logic done = 1'b0;

   initial begin
      // R1 reset state: clear wins over preset and enables
      step(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC, "R1 clear overrides load");
      // R2 preset with enables low, then with enables high
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h0FD, "R2 load enables low");
      step(1'b1, 1'b0, 1'b1, 1'b1, 12'h0FD, "R2 load overrides count");
      // R3/R7 count across slice boundaries
      for (int i = 0; i < 4; i++)
         step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R3 R7 count across slice");
      // R4 park slice 0 at all ones and hold with each enable low
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'h2FF, "R2 load 2FF");
      step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R4 hold en_par low");
      step(1'b1, 1'b1, 1'b1, 1'b0, 12'h000, "R4 hold en_trk low");
      step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R4 hold both low");
      step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R7 carry 2FF to 300");
      // R5 wrap from all ones; R6 tc at all ones
      step(1'b1, 1'b0, 1'b1, 1'b1, 12'hFFE, "R2 load FFE");
      step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R3 count to FFF");
      step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R6 tc ignores en_par");
      step(1'b1, 1'b0, 1'b1, 1'b0, 12'h123, "R6 tc low with en_trk low; R2 load");
      step(1'b1, 1'b0, 1'b0, 1'b1, 12'hFFF, "R2 load FFF");
      step(1'b0, 1'b0, 1'b1, 1'b1, 12'h000, "R6 tc under clear; R1 clear");
      step(1'b1, 1'b0, 1'b0, 1'b0, 12'hFFF, "R2 load FFF");
      step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R5 wrap FFF to 000");
      step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R3 count after wrap");
      // Long counting run
      for (int i = 0; i < 300; i++)
         step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R3 R7 long run");
      // Mixed sequence
      for (int i = 0; i < 400; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         step(r[7:4] != 4'd0, r[3:2] != 2'd0, r[1] | r[0] & r[2],
              r[0] | r[5], 12'($urandom), "R1 R2 R3 R4 mixed");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(5.0 * 50000);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule